// File: doc/BRIEF.md
# Presence-Tagged Synchronizing Memory

This block is a small synchronous word store in which every word carries a single presence flag. A word is either full (holds a value a producer has written) or empty (no value yet). A producer port writes words at any time: each write stores the data and marks the word full. A consumer port takes read and clear requests under a valid/ready handshake. A read of a full word returns its data on the next cycle, as an ordinary registered RAM read would. A read of an empty word is parked. The requester is held off until a producer writes that address, and the read then completes with the freshly written value.

Only one read can be parked at a time. While it waits, the request port drops ready, and the producer port keeps storing data. A clear request returns a word to empty, so the same location can carry the next value in a producer/consumer exchange. This gives per-word synchronization in hardware, with no polling loop and no separate lock variable.

Top module: `fe_mem`

## Requirements
- R1: After reset every word is empty, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A producer write (`wr_en`=1) stores `wr_data` at `wr_addr` and marks that word full at the same clock edge.
- R3: A read request (`req_op`=0) that is accepted while its word is full gives `rsp_valid`=1 with the stored data in the cycle after acceptance.
- R4: A read request that is accepted while its word is empty gives no response, and `req_ready` is 0 from the next cycle on.
- R5: While a read is parked, a producer write to the awaited address gives `rsp_valid`=1 with that write's data in the next cycle, and `req_ready` returns to 1 after it.
- R6: While a read is parked, producer writes to other addresses do not release it, and no new request is accepted (`req_ready`=0).
- R7: A clear request (`req_op`=1) marks the addressed word empty and never produces a response, so a later read of that word parks.
- R8: If a producer write and an accepted clear target the same word in the same cycle, the word ends up full with the written data.
- R9: A read accepted in the same cycle as a producer write to the same address returns the written data in the next cycle and does not park.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Consumer request present |
| req_ready | output | 1 | Request accepted this cycle if valid; low while a read is parked |
| req_op | input | 1 | 0 = read, 1 = clear |
| req_addr | input | AW | Word address of the request |
| rsp_valid | output | 1 | Read data valid, one cycle pulse |
| rsp_data | output | DW | Read data |
| wr_en | input | 1 | Producer write strobe |
| wr_addr | input | AW | Producer write address |
| wr_data | input | DW | Producer write data |

## Verification
The read path is tried against full words, never-written words, words that were cleared, and words written in the same cycle as the read. This separates the immediate-hit path, the parked path and the forwarding path. While a read is parked, writes to other addresses and an overlapping request are applied, to show that only a matching address releases the read and that the single waiting slot admits nothing else. A write and a clear to the same word in one cycle show which operation has priority.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_CLEAR = 1'b1
  } fe_op_e;
endpackage

// File: rtl/fe_store.sv
module fe_store #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_full
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    word_q [DEPTH];
  logic [DEPTH-1:0] full_q;

  always_ff @(posedge clk) begin
    if (wr_en) word_q[wr_addr] <= wr_data;
  end

  // one presence flag per word; a write beats a clear to the same word
  for (genvar i = 0; i < DEPTH; i++) begin : g_flag
    logic set_w, clr_w;
    assign set_w = wr_en  && (wr_addr  == AW'(i));
    assign clr_w = clr_en && (clr_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)     full_q[i] <= 1'b0;
      else if (set_w) full_q[i] <= 1'b1;
      else if (clr_w) full_q[i] <= 1'b0;
    end
  end

  assign rd_data = word_q[rd_addr];
  assign rd_full = full_q[rd_addr];
endmodule

// File: rtl/fe_wait.sv
module fe_wait #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          park,
  input  logic [AW-1:0] park_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          pending,
  output logic          release_o
);
  logic          pend_q;
  logic [AW-1:0] addr_q;

  function automatic logic wakes(input logic p, input logic we,
                                 input logic [AW-1:0] a, input logic [AW-1:0] b);
    return p && we && (a == b);
  endfunction

  assign release_o = wakes(pend_q, wr_en, wr_addr, addr_q);
  assign pending   = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else if (release_o) begin
      pend_q <= 1'b0;
    end else if (park) begin
      pend_q <= 1'b1;
      addr_q <= park_addr;
    end
  end
endmodule

// File: rtl/fe_resp.sv
module fe_resp #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic          wake,
  input  logic [DW-1:0] wake_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= hit || wake;
      if (wake)     rsp_data <= wake_data;
      else if (hit) rsp_data <= hit_data;
    end
  end
endmodule

// File: rtl/fe_mem.sv
module fe_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  import fe_pkg::*;

  logic          accept_w, rd_acc_w, clr_acc_w, bypass_w;
  logic          hit_w, park_w, release_w, pending_w, word_full_w;
  logic [DW-1:0] word_data_w, hit_data_w;
  fe_op_e        op_w;

  function automatic logic [DW-1:0] pick(input logic fwd, input logic [DW-1:0] fresh,
                                         input logic [DW-1:0] stored);
    return fwd ? fresh : stored;
  endfunction

  assign op_w      = fe_op_e'(req_op);
  assign req_ready = !pending_w;
  assign accept_w  = req_valid && req_ready;
  assign rd_acc_w  = accept_w && (op_w == OP_READ);
  assign clr_acc_w = accept_w && (op_w == OP_CLEAR);
  assign bypass_w  = wr_en && (wr_addr == req_addr);
  assign hit_w     = rd_acc_w && (word_full_w || bypass_w);
  assign park_w    = rd_acc_w && !(word_full_w || bypass_w);
  assign hit_data_w = pick(bypass_w, wr_data, word_data_w);

  fe_store #(.DW(DW), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .clr_en   (clr_acc_w),
    .clr_addr (req_addr),
    .rd_addr  (req_addr),
    .rd_data  (word_data_w),
    .rd_full  (word_full_w)
  );

  fe_wait #(.AW(AW)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .park      (park_w),
    .park_addr (req_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .pending   (pending_w),
    .release_o (release_w)
  );

  fe_resp #(.DW(DW)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit_w),
    .hit_data  (hit_data_w),
    .wake      (release_w),
    .wake_data (wr_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/fe_mem_chk.sv
module fe_mem_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic [DW-1:0] wr_data,
  input logic          evt_hit,
  input logic          evt_park,
  input logic          evt_release
);
  // R3
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> rsp_valid);

  // R4
  park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_park |=> !rsp_valid);

  // R6
  park_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_park |=> !req_ready);

  // R5
  release_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_release |=> (rsp_valid && rsp_data == $past(wr_data)));

  // R5
  release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_release |=> req_ready);
endmodule

bind fe_mem fe_mem_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .wr_data     (wr_data),
  .evt_hit     (hit_w),
  .evt_park    (park_w),
  .evt_release (release_w)
);

// File: tb/sim_fe_mem.sv
module sim_fe_mem;
  localparam int DW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fe_mem #(.DW(DW), .AW(AW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock of stimulus; called at a falling edge, returns at the next
  task automatic cyc(input logic rv, input logic op, input logic [AW-1:0] ra,
                     input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                     output logic rdy, output logic ov, output logic [DW-1:0] od);
    req_valid = rv; req_op = op; req_addr = ra;
    wr_en = we; wr_addr = wa; wr_data = wd;
    #1 rdy = req_ready;
    @(posedge clk);
    @(negedge clk);
    ov = rsp_valid;
    od = rsp_data;
    req_valid = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_hit();
    logic r, v; logic [DW-1:0] d;
    cyc(0, 0, 0, 1, 4'd2, 16'hA5A5, r, v, d);
    chk(v == 1'b0, "R2 write alone gives no response", 32'(v), 32'd0);
    cyc(1, 0, 4'd2, 0, 0, 0, r, v, d);
    chk(v == 1'b1 && d == 16'hA5A5, "R3 hit on written word", {15'd0, v, d}, {16'd1, 16'hA5A5});
    for (int i = 10; i < 14; i++) cyc(0, 0, 0, 1, AW'(i), DW'(i * 16'h1111), r, v, d);
    for (int i = 10; i < 14; i++) begin
      cyc(1, 0, AW'(i), 0, 0, 0, r, v, d);
      chk(v == 1'b1 && d == DW'(i * 16'h1111), "R2 R3 readback pattern",
          {15'd0, v, d}, {16'd1, 16'(i * 16'h1111)});
    end
  endtask

  task automatic t_stall();
    logic r, v; logic [DW-1:0] d;
    cyc(1, 0, 4'd5, 0, 0, 0, r, v, d);
    chk(r == 1'b1 && v == 1'b0, "R4 read of empty word parks", {r, v}, 32'b10);
    chk(req_ready == 1'b0, "R4 ready drops after park", 32'(req_ready), 32'd0);
    cyc(1, 0, 4'd2, 1, 4'd6, 16'h0606, r, v, d);
    chk(r == 1'b0 && v == 1'b0, "R6 other write no release, request blocked", {r, v}, 32'b00);
    cyc(0, 0, 0, 1, 4'd5, 16'hBEEF, r, v, d);
    chk(v == 1'b1 && d == 16'hBEEF, "R5 matching write releases", {15'd0, v, d}, {16'd1, 16'hBEEF});
    chk(req_ready == 1'b1, "R5 ready restored", 32'(req_ready), 32'd1);
  endtask

  task automatic t_clear();
    logic r, v; logic [DW-1:0] d;
    cyc(1, 1, 4'd2, 0, 0, 0, r, v, d);
    chk(r == 1'b1 && v == 1'b0, "R7 clear accepted, no response", {r, v}, 32'b10);
    cyc(1, 0, 4'd2, 0, 0, 0, r, v, d);
    chk(v == 1'b0 && req_ready == 1'b0, "R7 read after clear parks", {v, req_ready}, 32'b00);
    cyc(0, 0, 0, 1, 4'd2, 16'h1234, r, v, d);
    chk(v == 1'b1 && d == 16'h1234, "R7 refill releases", {15'd0, v, d}, {16'd1, 16'h1234});
  endtask

  task automatic t_write_vs_clear();
    logic r, v; logic [DW-1:0] d;
    cyc(0, 0, 0, 1, 4'd3, 16'h3333, r, v, d);
    cyc(1, 1, 4'd3, 1, 4'd3, 16'h7777, r, v, d);
    cyc(1, 0, 4'd3, 0, 0, 0, r, v, d);
    chk(v == 1'b1 && d == 16'h7777, "R8 write beats clear", {15'd0, v, d}, {16'd1, 16'h7777});
  endtask

  task automatic t_bypass();
    logic r, v; logic [DW-1:0] d;
    cyc(1, 0, 4'd9, 1, 4'd9, 16'h9999, r, v, d);
    chk(v == 1'b1 && d == 16'h9999, "R9 same-cycle write forwarded", {15'd0, v, d}, {16'd1, 16'h9999});
    chk(req_ready == 1'b1, "R9 no park on forwarded read", 32'(req_ready), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stall();
    t_hit();
    t_clear();
    t_write_vs_clear();
    t_bypass();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule